// File: doc/BRIEF.md
# Predicated Word Load-and-Broadcast Unit

This block decodes and runs one vector load form. It reads a single unsigned 32-bit word from memory. It then copies that word into every active element of a destination vector, and it writes zero to every inactive element. The caller presents a 32-bit instruction word together with three values: the general-purpose base register, the stack-pointer value, and the per-byte predicate chosen by the instruction. The block checks the encoding and picks a base. If at least one element is active, it issues one memory read for the word at base plus a scaled immediate and waits for the data. It then returns the finished vector to the register file in a one-cycle write pulse.

Two variants share the encoding. One fills 32-bit elements and the other fills 64-bit elements; the memory access is one 32-bit word in both. Each element reads the predicate bit of its lowest byte. If no element is active, the block skips the memory read completely and writes an all-zero vector. An encoding that matches neither variant gives a one-cycle undefined flag. A stack-pointer base whose low four bits are not all zero gives a one-cycle misalignment flag. Neither case writes the destination or touches memory.

Top module: `bcl_unit`

## Requirements
- R1: An instruction is valid only when bits 31..22 equal 1000010101 and bits 15..14 equal 11. Any other word raises `undef_o` for exactly the one cycle after acceptance. It issues no memory request and no write.
- R2: The request address is the base plus imm6 × 4, where imm6 is bits 21..16. The base is `in_sp` when bits 9..5 (the base index) equal 31, and `in_gpr` otherwise. `mem_req_valid` and `mem_req_addr` stay constant until `mem_req_ready` is seen, and exactly one request is made.
- R3: When the base index is 31 and `in_sp[3:0]` is not zero, `sp_misalign_o` pulses for one cycle after acceptance. No request is issued and no write is made.
- R4: With bit 13 clear, elements are 32 bits wide. Element e is active when `in_pred[4e]` is set. An active element receives the loaded word and an inactive element receives zero.
- R5: With bit 13 set, elements are 64 bits wide. Element e is active when `in_pred[8e]` is set. An active element receives the word zero-extended to 64 bits and an inactive element receives zero. All other predicate bits are ignored.
- R6: When no element is active, no memory request is issued. `wr_en` pulses in the cycle after acceptance with an all-zero `wr_data`.
- R7: After a memory response, `wr_en` pulses for exactly one cycle, in the cycle after the response. `wr_idx` carries bits 4..0 of the accepted instruction.
- R8: `in_ready` is low from acceptance of an active instruction until its response arrives. Instructions offered during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction accepted when valid |
| in_insn | input | 32 | Instruction word |
| in_gpr | input | 64 | Value of the named general-purpose base register |
| in_sp | input | 64 | Stack-pointer value |
| in_pred | input | VL/8 | Predicate register value, one bit per byte |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| wr_en | output | 1 | Destination write pulse |
| wr_idx | output | 5 | Destination vector register index |
| wr_data | output | VL | Destination vector value |
| undef_o | output | 1 | Undefined-encoding pulse |
| sp_misalign_o | output | 1 | Stack-pointer misalignment pulse |

## Verification
Some rules are checked on every cycle by the assertions. A pending request keeps its address while it waits. An undefined or misaligned instruction never comes out together with a write or a request. A write that completes a load follows a response. The busy request never coincides with readiness for a new instruction. Only the bench scenarios can show the data-dependent behaviour. This covers the scaled address, including a carry out of the low bits, and the choice of predicate bit per element in each width. It also covers the all-inactive zero write that skips memory, and the way an instruction offered while busy is ignored.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

    localparam logic [9:0] BCL_OPCODE = 10'b1000010101;
    localparam logic [4:0] BCL_SP_IDX = 5'd31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2
    } bcl_state_e;

    typedef struct packed {
        logic       ok;
        logic       wide;
        logic [5:0] imm;
        logic [2:0] pg;
        logic [4:0] rn;
        logic [4:0] zt;
    } bcl_dec_t;

endpackage

// File: rtl/bcl_decode.sv
module bcl_decode
    import bcl_pkg::*;
(
    input  logic [31:0] insn,
    output bcl_dec_t    dec
);

    always_comb begin
        dec.ok   = (insn[31:22] == BCL_OPCODE) && (insn[15:14] == 2'b11);
        dec.wide = insn[13];
        dec.imm  = insn[21:16];
        dec.pg   = insn[12:10];
        dec.rn   = insn[9:5];
        dec.zt   = insn[4:0];
    end

endmodule

// File: rtl/bcl_lanes.sv
module bcl_lanes #(
    parameter int VL = 256
) (
    input  logic [VL/8-1:0] pred,
    input  logic            wide,
    input  logic [31:0]     word,
    output logic [VL-1:0]   data,
    output logic            any_act
);

    localparam int LANES = VL / 32;

    logic [LANES-1:0] act;

    // Lane i covers bytes 4i..4i+3; an even lane also starts a 64-bit element.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i % 2 == 0) begin : g_even
            assign act[i] = pred[i*4];
        end else begin : g_odd
            assign act[i] = pred[i*4] & ~wide;
        end
        assign data[i*32 +: 32] = act[i] ? word : 32'd0;
    end

    assign any_act = |act;

endmodule

// File: rtl/bcl_unit.sv
module bcl_unit
    import bcl_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [31:0]     in_insn,
    input  logic [63:0]     in_gpr,
    input  logic [63:0]     in_sp,
    input  logic [VL/8-1:0] in_pred,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [63:0]     mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [31:0]     mem_rsp_data,
    output logic            wr_en,
    output logic [4:0]      wr_idx,
    output logic [VL-1:0]   wr_data,
    output logic            undef_o,
    output logic            sp_misalign_o
);

    localparam int PL = VL / 8;

    typedef struct packed {
        bcl_state_e      st;
        logic [63:0]     addr;
        logic            wide;
        logic [PL-1:0]   pred;
        logic [4:0]      zt;
        logic            wr_en;
        logic [VL-1:0]   wr_data;
        logic            undef;
        logic            misalign;
    } bcl_regs_t;

    bcl_regs_t r_q, r_d;
    bcl_dec_t  dec;

    logic [PL-1:0] lane_pred;
    logic          lane_wide;
    logic [VL-1:0] lane_data;
    logic          lane_any;
    logic [63:0]   base;
    logic          use_sp;

    bcl_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    assign lane_pred = (r_q.st == ST_IDLE) ? in_pred   : r_q.pred;
    assign lane_wide = (r_q.st == ST_IDLE) ? dec.wide  : r_q.wide;

    bcl_lanes #(.VL(VL)) u_lanes (
        .pred    (lane_pred),
        .wide    (lane_wide),
        .word    (mem_rsp_data),
        .data    (lane_data),
        .any_act (lane_any)
    );

    assign use_sp = (dec.rn == BCL_SP_IDX);
    assign base   = use_sp ? in_sp : in_gpr;

    always_comb begin
        r_d          = r_q;
        r_d.wr_en    = 1'b0;
        r_d.undef    = 1'b0;
        r_d.misalign = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (!dec.ok) begin
                        r_d.undef = 1'b1;
                    end else if (use_sp && (in_sp[3:0] != 4'd0)) begin
                        r_d.misalign = 1'b1;
                    end else if (!lane_any) begin
                        r_d.wr_en   = 1'b1;
                        r_d.wr_data = '0;
                        r_d.zt      = dec.zt;
                    end else begin
                        r_d.st   = ST_REQ;
                        r_d.addr = base + {56'd0, dec.imm, 2'b00};
                        r_d.wide = dec.wide;
                        r_d.pred = in_pred;
                        r_d.zt   = dec.zt;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) r_d.st = ST_RSP;
            end
            ST_RSP: begin
                if (mem_rsp_valid) begin
                    r_d.st      = ST_IDLE;
                    r_d.wr_en   = 1'b1;
                    r_d.wr_data = lane_data;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready      = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_REQ);
    assign mem_req_addr  = r_q.addr;
    assign wr_en         = r_q.wr_en;
    assign wr_idx        = r_q.zt;
    assign wr_data       = r_q.wr_data;
    assign undef_o       = r_q.undef;
    assign sp_misalign_o = r_q.misalign;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> !wr_en && !mem_req_valid); // R1

    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sp_misalign_o |-> !wr_en && !mem_req_valid); // R3

    AST_WRITE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(r_q.st == ST_RSP) |-> $past(mem_rsp_valid)); // R7

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, undef_o, sp_misalign_o})); // R7

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !in_ready); // R8

endmodule

// File: tb/tb_bcl_unit.sv
`timescale 1ns/1ps
module tb_bcl_unit;

    localparam int VL = 256;
    localparam int PL = VL / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [31:0]     in_insn = '0;
    logic [63:0]     in_gpr = '0;
    logic [63:0]     in_sp = '0;
    logic [PL-1:0]   in_pred = '0;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic [63:0]     mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [31:0]     mem_rsp_data = '0;
    logic            wr_en;
    logic [4:0]      wr_idx;
    logic [VL-1:0]   wr_data;
    logic            undef_o;
    logic            sp_misalign_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  exp_ready = 1'b1;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    bcl_unit #(.VL(VL)) dut (.*);

    task automatic chk(bit ok, string rq, logic [VL-1:0] act, logic [VL-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // per-cycle comparison of readiness against the bench's own busy model
    always @(negedge clk) begin
        if (rst_n && !done) chk(in_ready == exp_ready, "R8 in_ready", VL'(in_ready), VL'(exp_ready));
    end

    function automatic logic [31:0] mk(logic [5:0] imm, logic wide, logic [4:0] rn, logic [4:0] zt);
        return {10'b1000010101, imm, 2'b11, wide, 3'd2, rn, zt};
    endfunction

    function automatic logic [VL-1:0] model_vec(bit wide, logic [PL-1:0] p, logic [31:0] w);
        logic [VL-1:0] v = '0;
        int es = wide ? 64 : 32;
        for (int e = 0; e < VL / es; e++)
            if (p[e*es/8]) v[e*es +: 32] = w;
        return v;
    endfunction

    function automatic bit model_any(bit wide, logic [PL-1:0] p);
        int es = wide ? 64 : 32;
        for (int e = 0; e < VL / es; e++)
            if (p[e*es/8]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic run(logic [31:0] insn, logic [63:0] gpr, logic [63:0] sp,
                       logic [PL-1:0] pred, logic [31:0] word, int rdly, int sdly);
        bit            ok   = (insn[31:22] == 10'b1000010101) && (insn[15:14] == 2'b11);
        bit            wide = insn[13];
        logic [4:0]    rn   = insn[9:5];
        logic [63:0]   b    = (rn == 5'd31) ? sp : gpr;
        logic [63:0]   ea   = b + 64'(insn[21:16]) * 64'd4;
        logic [VL-1:0] ev   = model_vec(wide, pred, word);
        in_valid = 1'b1; in_insn = insn; in_gpr = gpr; in_sp = sp; in_pred = pred;
        step();
        in_valid = 1'b0;
        if (!ok) begin
            chk(undef_o == 1'b1, "R1 undef pulse", VL'(undef_o), VL'(1));
            chk(!wr_en && !mem_req_valid, "R1 no write/req", VL'({wr_en, mem_req_valid}), '0);
            step();
            chk(undef_o == 1'b0, "R1 single pulse", VL'(undef_o), '0);
        end else if (rn == 5'd31 && sp[3:0] != 4'd0) begin
            chk(sp_misalign_o == 1'b1, "R3 misalign pulse", VL'(sp_misalign_o), VL'(1));
            chk(!wr_en && !mem_req_valid, "R3 no write/req", VL'({wr_en, mem_req_valid}), '0);
            step();
            chk(sp_misalign_o == 1'b0, "R3 single pulse", VL'(sp_misalign_o), '0);
        end else if (!model_any(wide, pred)) begin
            chk(wr_en == 1'b1, "R6 zero write", VL'(wr_en), VL'(1));
            chk(wr_data == '0, "R6 zero data", wr_data, '0);
            chk(wr_idx == insn[4:0], "R7 index", VL'(wr_idx), VL'(insn[4:0]));
            chk(mem_req_valid == 1'b0, "R6 no request", VL'(mem_req_valid), '0);
            step();
            chk(wr_en == 1'b0 && mem_req_valid == 1'b0, "R6 quiet after", VL'({wr_en, mem_req_valid}), '0);
        end else begin
            exp_ready = 1'b0;
            chk(mem_req_valid == 1'b1, "R2 request", VL'(mem_req_valid), VL'(1));
            chk(mem_req_addr == ea, "R2 address", VL'(mem_req_addr), VL'(ea));
            in_valid = 1'b1; in_insn = 32'hFFFF_FFFF;  // ignored while busy (R8)
            for (int i = 0; i < rdly; i++) begin
                step();
                chk(mem_req_valid && mem_req_addr == ea, "R2 request held", VL'(mem_req_addr), VL'(ea));
            end
            mem_req_ready = 1'b1;
            step();
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0 && wr_en == 1'b0, "R2 single request", VL'({mem_req_valid, wr_en}), '0);
            for (int i = 0; i < sdly; i++) begin
                step();
                chk(wr_en == 1'b0 && mem_req_valid == 1'b0, "R7 wait response", VL'(wr_en), '0);
            end
            in_valid = 1'b0;
            mem_rsp_valid = 1'b1; mem_rsp_data = word;
            step();
            mem_rsp_valid = 1'b0;
            exp_ready = 1'b1;
            chk(wr_en == 1'b1, "R7 write pulse", VL'(wr_en), VL'(1));
            chk(wr_idx == insn[4:0], "R7 index", VL'(wr_idx), VL'(insn[4:0]));
            chk(wr_data == ev, wide ? "R5 data" : "R4 data", wr_data, ev);
            chk(undef_o == 1'b0, "R8 busy insn ignored", VL'(undef_o), '0);
            step();
            chk(wr_en == 1'b0 && undef_o == 1'b0, "R7 single pulse", VL'({wr_en, undef_o}), '0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(!wr_en && !undef_o && !sp_misalign_o && !mem_req_valid, "R7 reset quiet",
            VL'({wr_en, undef_o, sp_misalign_o, mem_req_valid}), '0);
        rst_n = 1'b1;
        step();
        chk(in_ready == 1'b1, "R8 ready after reset", VL'(in_ready), VL'(1));

        // R4: 32-bit elements, odd-byte predicate bits must be ignored
        run(mk(6'd5, 1'b0, 5'd3, 5'd7), 64'h1000, 64'h0, 32'h0000_1012, 32'hDEAD_BEEF, 2, 1);
        // R5: 64-bit elements, pred[4] set but element 0 inactive
        run(mk(6'd1, 1'b1, 5'd0, 5'd9), 64'h2222_0000, 64'h0, 32'h0101_0010, 32'h1234_5678, 0, 0);
        // R2: stack-pointer base, maximal offset with carry
        run(mk(6'd63, 1'b0, 5'd31, 5'd31), 64'h0, 64'h0000_0000_FFFF_FFF0, 32'hFFFF_FFFF, 32'hA5A5_0001, 1, 3);
        // R3: misaligned stack pointer
        run(mk(6'd2, 1'b0, 5'd31, 5'd1), 64'h0, 64'h0000_0000_0000_1008, 32'hFFFF_FFFF, 32'h1, 0, 0);
        // R1: bad opcode and bad size field
        run(32'h8540_0000 ^ 32'h0040_0000 | 32'h0000_C000, 64'h0, 64'h0, 32'hFFFF_FFFF, 32'h1, 0, 0);
        run({10'b1000010101, 6'd0, 3'b101, 13'd0}, 64'h0, 64'h0, 32'hFFFF_FFFF, 32'h1, 0, 0);
        // R6: no active 32-bit element
        run(mk(6'd4, 1'b0, 5'd2, 5'd4), 64'h40, 64'h0, 32'hEEEE_EEEE, 32'h7, 0, 0);
        // R6: 64-bit with only 32-bit-position bits set
        run(mk(6'd4, 1'b1, 5'd2, 5'd5), 64'h40, 64'h0, 32'h1010_1010, 32'h7, 0, 0);
        // R4: all active
        run(mk(6'd0, 1'b0, 5'd8, 5'd0), 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 32'hFFFF_FFFF, 32'h8000_0001, 0, 2);
        // R5: all active, wide
        run(mk(6'd10, 1'b1, 5'd31, 5'd12), 64'h0, 64'h100, 32'hFFFF_FFFF, 32'hCAFE_F00D, 3, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule